// File: doc/BRIEF.md
# Accumulator Arithmetic and Bit-Manipulation Unit

This block computes the next value of an 8-bit accumulator. It takes the current accumulator, one register operand and one immediate byte, and a 3-bit group code selects one of several operation families. Within a family, a 3-bit operation select picks the function. The families are one-operand arithmetic and shifts, two-operand arithmetic, logic and shifts against the register, an unsigned less-than test, single-bit and shift operations indexed by an immediate, logic against a full immediate byte, and two add-immediate forms. Two's-complement arithmetic wraps modulo 2^8.

The result is captured in an output register, so each new value appears one clock after its operands. Decode logic drives the group and select fields and then writes the result back to the accumulator. The register file, decode and flag storage are outside this block.

Top module: `acc_alu`

## Requirements
- R1: `result_o` is registered. Operands presented before a rising edge give their result after that edge. While `rst` is high at an edge, `result_o` becomes 0.
- R2: Group 0 (one-operand) select codes: 0 gives zero, 1 shifts left by one, 2 shifts right by one with zero fill, 3 shifts right by one with sign fill, 4 adds one, 5 subtracts one, 6 inverts every bit, 7 gives the two's-complement negation.
- R3: Group 1 (register) select codes 0 to 4 give accumulator plus register, accumulator minus register, AND, OR and XOR. Sums and differences wrap modulo 256.
- R4: Group 1 select codes 5, 6 and 7 shift the accumulator left, right with zero fill, and right with sign fill. The shift amount is the full register value. Amounts of 8 or more give all zeros, or all copies of bit 7 for the sign-filling shift.
- R5: Group 2 gives 1 when the accumulator is below the register as unsigned numbers, and 0 otherwise. The select field is ignored.
- R6: Group 3 select codes 0 to 3 rotate left, shift left, shift right with zero fill, and shift right with sign fill. The amount is `imm_i[2:0]`, and `imm_i[7:3]` is ignored.
- R7: Group 3 select codes 4 to 7 act on the bit indexed by `imm_i[2:0]`: 4 clears it, 5 sets it, 6 inverts it, and 7 returns it in bit 0 with every other bit zero.
- R8: Group 4 select codes 0, 1 and 2 give the accumulator ANDed, ORed and XORed with `imm_i`. Codes 3 to 7 return the accumulator unchanged.
- R9: Group 5 adds `imm_i[6:0]` zero-extended. `imm_i[7]` and the select field are ignored.
- R10: Group 6 adds `imm_i[5:0]` sign-extended to 8 bits. `imm_i[7:6]` and the select field are ignored.
- R11: Group 7 returns the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| grp_i | input | 3 | Operation group code |
| op_i | input | 3 | Operation select within the group |
| acc_i | input | 8 | Current accumulator value |
| reg_i | input | 8 | Register operand |
| imm_i | input | 8 | Immediate byte |
| result_o | output | 8 | Registered next accumulator value |

## Verification
Every result arrives exactly one rising edge after its operands. Reset clears the output at the first edge where it is high. The bench drives operands on a falling edge and samples `result_o` on the next falling edge, half a period after the capturing edge. This keeps every check on that one-cycle schedule. Consecutive table vectors are applied back to back, so a stale or doubly delayed value would show as a mismatch. The bound properties compare each output with operands taken through `$past` of depth one.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        GRP_UNARY = 3'd0,
        GRP_REG   = 3'd1,
        GRP_LESS  = 3'd2,
        GRP_BIT   = 3'd3,
        GRP_LOGIC = 3'd4,
        GRP_ADDU  = 3'd5,
        GRP_ADDS  = 3'd6,
        GRP_PASS  = 3'd7
    } grp_e;

    typedef enum logic [2:0] {
        UN_ZERO = 3'd0, UN_SHL = 3'd1, UN_SHR = 3'd2, UN_SAR = 3'd3,
        UN_INC  = 3'd4, UN_DEC = 3'd5, UN_NOT = 3'd6, UN_NEG = 3'd7
    } unary_op_e;

    typedef enum logic [2:0] {
        RG_ADD = 3'd0, RG_SUB = 3'd1, RG_AND = 3'd2, RG_OR  = 3'd3,
        RG_XOR = 3'd4, RG_SHL = 3'd5, RG_SHR = 3'd6, RG_SAR = 3'd7
    } reg_op_e;

    typedef enum logic [2:0] {
        BT_ROL = 3'd0, BT_SHL = 3'd1, BT_SHR = 3'd2, BT_SAR = 3'd3,
        BT_CLR = 3'd4, BT_SET = 3'd5, BT_FLIP = 3'd6, BT_PICK = 3'd7
    } bit_op_e;

    typedef struct packed {
        grp_e       grp;
        logic [2:0] op;
    } sel_t;

endpackage

// File: rtl/acc_unary.sv
module acc_unary
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  unary_op_e    op_i,
    output logic [W-1:0] y_o
);

    always_comb begin
        unique case (op_i)
            UN_ZERO: y_o = '0;
            UN_SHL:  y_o = {a_i[W-2:0], 1'b0};
            UN_SHR:  y_o = {1'b0, a_i[W-1:1]};
            UN_SAR:  y_o = {a_i[W-1], a_i[W-1:1]};
            UN_INC:  y_o = a_i + W'(1);
            UN_DEC:  y_o = a_i - W'(1);
            UN_NOT:  y_o = ~a_i;
            UN_NEG:  y_o = W'(0) - a_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/acc_regop.sv
module acc_regop
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] r_i,
    input  reg_op_e      op_i,
    output logic [W-1:0] y_o,
    output logic [W-1:0] less_o
);

    localparam int SHW = $clog2(W);

    logic           too_far;
    logic [SHW-1:0] amt;

    assign too_far = |r_i[W-1:SHW];
    assign amt     = r_i[SHW-1:0];
    assign less_o  = {{(W-1){1'b0}}, (a_i < r_i)};

    always_comb begin
        unique case (op_i)
            RG_ADD:  y_o = a_i + r_i;
            RG_SUB:  y_o = a_i - r_i;
            RG_AND:  y_o = a_i & r_i;
            RG_OR:   y_o = a_i | r_i;
            RG_XOR:  y_o = a_i ^ r_i;
            RG_SHL:  y_o = too_far ? '0 : (a_i << amt);
            RG_SHR:  y_o = too_far ? '0 : (a_i >> amt);
            RG_SAR:  y_o = too_far ? {W{a_i[W-1]}} : W'($signed(a_i) >>> amt);
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/acc_immop.sv
module acc_immop
    import acc_alu_pkg::*;
#(
    parameter int W     = DATA_W,
    parameter int ADDU_W = 7,
    parameter int ADDS_W = 6
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] imm_i,
    input  sel_t         sel_i,
    output logic [W-1:0] y_o
);

    localparam int IDXW = $clog2(W);

    logic [IDXW-1:0] idx;
    logic [W-1:0]    mask;
    logic [2*W-1:0]  spun;
    logic [W-1:0]    bit_y;
    logic [W-1:0]    logic_y;
    logic [W-1:0]    addu_k;
    logic [W-1:0]    adds_k;

    assign idx    = imm_i[IDXW-1:0];
    assign mask   = W'(1) << idx;
    assign spun   = {a_i, a_i} << idx;
    assign addu_k = {{(W-ADDU_W){1'b0}}, imm_i[ADDU_W-1:0]};
    assign adds_k = {{(W-ADDS_W){imm_i[ADDS_W-1]}}, imm_i[ADDS_W-1:0]};

    always_comb begin
        unique case (bit_op_e'(sel_i.op))
            BT_ROL:  bit_y = spun[2*W-1:W];
            BT_SHL:  bit_y = a_i << idx;
            BT_SHR:  bit_y = a_i >> idx;
            BT_SAR:  bit_y = W'($signed(a_i) >>> idx);
            BT_CLR:  bit_y = a_i & ~mask;
            BT_SET:  bit_y = a_i | mask;
            BT_FLIP: bit_y = a_i ^ mask;
            BT_PICK: bit_y = {{(W-1){1'b0}}, a_i[idx]};
            default: bit_y = a_i;
        endcase
    end

    always_comb begin
        case (sel_i.op)
            3'd0:    logic_y = a_i & imm_i;
            3'd1:    logic_y = a_i | imm_i;
            3'd2:    logic_y = a_i ^ imm_i;
            default: logic_y = a_i;
        endcase
    end

    always_comb begin
        case (sel_i.grp)
            GRP_BIT:   y_o = bit_y;
            GRP_LOGIC: y_o = logic_y;
            GRP_ADDU:  y_o = a_i + addu_k;
            GRP_ADDS:  y_o = a_i + adds_k;
            default:   y_o = a_i;
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W      = DATA_W,
    parameter int ADDU_W = 7,
    parameter int ADDS_W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [2:0]   grp_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] reg_i,
    input  logic [W-1:0] imm_i,
    output logic [W-1:0] result_o
);

    sel_t         sel;
    logic [W-1:0] un_y;
    logic [W-1:0] rg_y;
    logic [W-1:0] lt_y;
    logic [W-1:0] im_y;
    logic [W-1:0] next_acc;
    logic [W-1:0] result_q;

    assign sel.grp = grp_e'(grp_i);
    assign sel.op  = op_i;

    acc_unary #(.W(W)) u_unary (
        .a_i  (acc_i),
        .op_i (unary_op_e'(op_i)),
        .y_o  (un_y)
    );

    acc_regop #(.W(W)) u_regop (
        .a_i    (acc_i),
        .r_i    (reg_i),
        .op_i   (reg_op_e'(op_i)),
        .y_o    (rg_y),
        .less_o (lt_y)
    );

    acc_immop #(.W(W), .ADDU_W(ADDU_W), .ADDS_W(ADDS_W)) u_immop (
        .a_i   (acc_i),
        .imm_i (imm_i),
        .sel_i (sel),
        .y_o   (im_y)
    );

    always_comb begin
        unique case (sel.grp)
            GRP_UNARY: next_acc = un_y;
            GRP_REG:   next_acc = rg_y;
            GRP_LESS:  next_acc = lt_y;
            GRP_PASS:  next_acc = acc_i;
            default:   next_acc = im_y;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) result_q <= '0;
        else     result_q <= next_acc;
    end

    assign result_o = result_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [2:0]   grp_i,
    input logic [2:0]   op_i,
    input logic [W-1:0] acc_i,
    input logic [W-1:0] imm_i,
    input logic [W-1:0] result_o
);

    assert_zero_op_R2: assert property (@(posedge clk) disable iff (rst)
        (grp_i == 3'd0 && op_i == 3'd0) |=> (result_o == '0));

    assert_invert_op_R2: assert property (@(posedge clk) disable iff (rst)
        (grp_i == 3'd0 && op_i == 3'd6) |=> (result_o == ~$past(acc_i)));

    assert_less_is_bool_R5: assert property (@(posedge clk) disable iff (rst)
        (grp_i == 3'd2) |=> (result_o[W-1:1] == '0));

    assert_pick_one_bit_R7: assert property (@(posedge clk) disable iff (rst)
        (grp_i == 3'd3 && op_i == 3'd7) |=> ($countones(result_o) <= 1 && result_o[W-1:1] == '0));

    assert_and_within_imm_R8: assert property (@(posedge clk) disable iff (rst)
        (grp_i == 3'd4 && op_i == 3'd0) |=> ((result_o & ~$past(imm_i)) == '0));

    assert_pass_through_R11: assert property (@(posedge clk) disable iff (rst)
        (grp_i == 3'd7) |=> (result_o == $past(acc_i)));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .grp_i    (grp_i),
    .op_i     (op_i),
    .acc_i    (acc_i),
    .imm_i    (imm_i),
    .result_o (result_o)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;

    localparam int NV = 49;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] grp;
    logic [2:0] op;
    logic [7:0] acc;
    logic [7:0] rv;
    logic [7:0] imm;
    logic [7:0] result;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    acc_alu u_acc_alu (
        .clk      (clk),
        .rst      (rst),
        .grp_i    (grp),
        .op_i     (op),
        .acc_i    (acc),
        .reg_i    (rv),
        .imm_i    (imm),
        .result_o (result)
    );

    // {req, grp, op, acc, reg, imm, expected}
    localparam logic [41:0] VEC [NV] = '{
        {4'd2,  3'd0, 3'd0, 8'h5A, 8'h00, 8'h00, 8'h00},  // R2 zero
        {4'd2,  3'd0, 3'd1, 8'h81, 8'h00, 8'h00, 8'h02},  // R2 shift left 1
        {4'd2,  3'd0, 3'd2, 8'h81, 8'h00, 8'h00, 8'h40},  // R2 shift right 1
        {4'd2,  3'd0, 3'd3, 8'h81, 8'h00, 8'h00, 8'hC0},  // R2 sign shift 1
        {4'd2,  3'd0, 3'd4, 8'hFF, 8'h00, 8'h00, 8'h00},  // R2 increment wraps
        {4'd2,  3'd0, 3'd5, 8'h00, 8'h00, 8'h00, 8'hFF},  // R2 decrement wraps
        {4'd2,  3'd0, 3'd6, 8'h5A, 8'h00, 8'h00, 8'hA5},  // R2 invert
        {4'd2,  3'd0, 3'd7, 8'h01, 8'h00, 8'h00, 8'hFF},  // R2 negate
        {4'd2,  3'd0, 3'd7, 8'h80, 8'h00, 8'h00, 8'h80},  // R2 negate most negative
        {4'd3,  3'd1, 3'd0, 8'hF0, 8'h20, 8'h00, 8'h10},  // R3 add wraps
        {4'd3,  3'd1, 3'd1, 8'h10, 8'h20, 8'h00, 8'hF0},  // R3 sub borrows
        {4'd3,  3'd1, 3'd2, 8'hF0, 8'h3C, 8'h00, 8'h30},  // R3 and
        {4'd3,  3'd1, 3'd3, 8'hF0, 8'h0F, 8'h00, 8'hFF},  // R3 or
        {4'd3,  3'd1, 3'd4, 8'hFF, 8'h0F, 8'h00, 8'hF0},  // R3 xor
        {4'd4,  3'd1, 3'd5, 8'h03, 8'h02, 8'h00, 8'h0C},  // R4 shl 2
        {4'd4,  3'd1, 3'd6, 8'h80, 8'h07, 8'h00, 8'h01},  // R4 shr 7
        {4'd4,  3'd1, 3'd7, 8'h80, 8'h03, 8'h00, 8'hF0},  // R4 sar 3
        {4'd4,  3'd1, 3'd5, 8'h01, 8'h08, 8'h00, 8'h00},  // R4 shl 8 saturates
        {4'd4,  3'd1, 3'd7, 8'h80, 8'h09, 8'h00, 8'hFF},  // R4 sar 9 sign fill
        {4'd4,  3'd1, 3'd7, 8'h40, 8'h20, 8'h00, 8'h00},  // R4 sar 32 positive
        {4'd4,  3'd1, 3'd6, 8'hFF, 8'h0A, 8'h00, 8'h00},  // R4 shr 10 not truncated
        {4'd5,  3'd2, 3'd0, 8'h05, 8'h06, 8'h00, 8'h01},  // R5 below
        {4'd5,  3'd2, 3'd5, 8'h06, 8'h06, 8'h00, 8'h00},  // R5 equal
        {4'd5,  3'd2, 3'd3, 8'h7F, 8'h80, 8'h00, 8'h01},  // R5 unsigned
        {4'd5,  3'd2, 3'd7, 8'hFF, 8'h01, 8'h00, 8'h00},  // R5 above
        {4'd6,  3'd3, 3'd0, 8'h81, 8'h00, 8'h01, 8'h03},  // R6 rotate 1
        {4'd6,  3'd3, 3'd0, 8'h81, 8'h00, 8'hFB, 8'h0C},  // R6 rotate 3, high imm ignored
        {4'd6,  3'd3, 3'd0, 8'hA5, 8'h00, 8'hF8, 8'hA5},  // R6 rotate 0
        {4'd6,  3'd3, 3'd1, 8'h01, 8'h00, 8'h07, 8'h80},  // R6 shl 7
        {4'd6,  3'd3, 3'd2, 8'h80, 8'h00, 8'h04, 8'h08},  // R6 shr 4
        {4'd6,  3'd3, 3'd3, 8'h80, 8'h00, 8'h02, 8'hE0},  // R6 sar 2
        {4'd7,  3'd3, 3'd4, 8'hFF, 8'h00, 8'h03, 8'hF7},  // R7 clear bit 3
        {4'd7,  3'd3, 3'd5, 8'h00, 8'h00, 8'h07, 8'h80},  // R7 set bit 7
        {4'd7,  3'd3, 3'd6, 8'h55, 8'h00, 8'h00, 8'h54},  // R7 flip bit 0
        {4'd7,  3'd3, 3'd7, 8'hA0, 8'h00, 8'h05, 8'h01},  // R7 pick bit 5
        {4'd7,  3'd3, 3'd7, 8'hA0, 8'h00, 8'hF6, 8'h00},  // R7 pick bit 6
        {4'd8,  3'd4, 3'd0, 8'h3C, 8'h00, 8'h0F, 8'h0C},  // R8 and imm
        {4'd8,  3'd4, 3'd1, 8'h30, 8'h00, 8'h03, 8'h33},  // R8 or imm
        {4'd8,  3'd4, 3'd2, 8'hFF, 8'h00, 8'hAA, 8'h55},  // R8 xor imm
        {4'd8,  3'd4, 3'd5, 8'h77, 8'h00, 8'hFF, 8'h77},  // R8 unused code keeps acc
        {4'd8,  3'd4, 3'd3, 8'h12, 8'h00, 8'h00, 8'h12},  // R8 unused code keeps acc
        {4'd9,  3'd5, 3'd0, 8'h10, 8'h00, 8'h85, 8'h15},  // R9 bit 7 ignored
        {4'd9,  3'd5, 3'd6, 8'h01, 8'h00, 8'h7F, 8'h80},  // R9 max field
        {4'd10, 3'd6, 3'd0, 8'h10, 8'h00, 8'h3F, 8'h0F},  // R10 minus one
        {4'd10, 3'd6, 3'd2, 8'h10, 8'h00, 8'hE0, 8'hF0},  // R10 minus 32, top bits ignored
        {4'd10, 3'd6, 3'd0, 8'h10, 8'h00, 8'h1F, 8'h2F},  // R10 plus 31
        {4'd11, 3'd7, 3'd0, 8'h9C, 8'h55, 8'hAA, 8'h9C},  // R11 pass
        {4'd11, 3'd7, 3'd6, 8'h03, 8'hFF, 8'hFF, 8'h03},  // R11 pass, op ignored
        {4'd1,  3'd0, 3'd6, 8'h00, 8'h00, 8'h00, 8'hFF}   // R1 back-to-back latency
    };

    task automatic check(input int req, input logic [7:0] exp, input string what);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, result, exp);
        end
    endtask

    task automatic drive(input logic [2:0] g, input logic [2:0] o,
                         input logic [7:0] a, input logic [7:0] r, input logic [7:0] i);
        grp = g; op = o; acc = a; rv = r; imm = i;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(3'd7, 3'd0, 8'hAB, 8'h00, 8'h00);
        @(negedge clk);
        @(negedge clk);
        check(1, 8'h00, "reset clears output");  // R1

        rst = 1'b0;
        // R1: result appears one edge after operands, checked in the table walk
        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][37:35], VEC[k][34:32], VEC[k][31:24], VEC[k][23:16], VEC[k][15:8]);
            @(negedge clk);
            check(int'(VEC[k][41:38]), VEC[k][7:0], $sformatf("vector %0d", k));
        end

        // R1: output holds stale value until the edge, then updates
        drive(3'd7, 3'd0, 8'h3E, 8'h00, 8'h00);
        @(negedge clk);
        drive(3'd7, 3'd0, 8'hC1, 8'h00, 8'h00);
        #1;
        check(1, 8'h3E, "no update before edge");
        @(negedge clk);
        check(1, 8'hC1, "update after one edge");

        // R1: reset mid-stream overrides a live operation
        rst = 1'b1;
        drive(3'd0, 3'd6, 8'h00, 8'h00, 8'h00);
        @(negedge clk);
        check(1, 8'h00, "reset during operation");
        rst = 1'b0;
        @(negedge clk);
        check(1, 8'hFF, "first result after reset");

        // R5: all-ones register compare
        drive(3'd2, 3'd0, 8'hFE, 8'hFF, 8'h00);
        @(negedge clk);
        check(5, 8'h01, "FE below FF");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule